// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a clocked host to an external asynchronous static RAM of 262144 words by 16 bits. The RAM has one shared bidirectional data bus and an active-low strobe for each byte lane. The host issues one request at a time over a valid/ready handshake. Each request carries a direction, an 18-bit word address, 16 bits of write data and a 2-bit byte mask. The controller returns a one-cycle response pulse with the read data.

Every access that enables at least one lane runs through three timed phases, each `PHASE_CYC` clock cycles long. The first phase settles the address, and on a write also the data. In the second phase chip select, the lane strobes and either the write or the output-enable strobe are active. In the third phase all strobes are released, while the address and write data stay on the pins. Because the RAM captures write data on whichever strobe rises first, the hold phase keeps the data valid past every strobe edge. Memory pins are driven from flops, so strobe edges come out clean. The data-bus driver enable is a separate output that controls the board-level tristate buffer.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted, and once it has been released, the chip select, write, output-enable and both lane strobes are high (inactive), the data driver enable is 0, rsp_valid is 0 and req_ready is 1.
- R2: A request with a nonzero mask is accepted when req_valid and req_ready are both high at a clock edge. req_ready then stays low until the access ends. The access runs a setup phase, an active phase and a hold phase of PHASE_CYC cycles each, with chip select high in the first cycle after acceptance. rsp_valid pulses for one cycle, 3*PHASE_CYC cycles after the accepting edge.
- R3: During a write, write enable goes low together with chip select, and output enable stays high for the whole write.
- R4: For a write, the address and write data appear on the pins and the driver enable goes to 1 in the setup phase. All three stay unchanged through the hold phase, so after every strobe has risen they are still valid.
- R5: A read drives write enable high and output enable and chip select low. The read data is captured on the last cycle of the active phase, so the RAM gets the full phase to respond. In rsp_rdata a lane whose mask bit is 0 reads as zero, and rsp_rdata is zero for writes.
- R6: Mask bit 0 drives the lower-byte strobe (data bits 7:0) and mask bit 1 drives the upper-byte strobe (bits 15:8). A lane whose mask bit is 0 has its strobe held high, so its stored byte is left unchanged.
- R7: Suppose a write is accepted and the last access that asserted strobes was a read. One extra cycle is then inserted before the setup phase, with output enable high and the driver enable 0, so the response comes 3*PHASE_CYC+1 cycles after acceptance. A zero-mask request does not count as the last access.
- R8: A request with mask 0 asserts no memory strobe. Its response pulses in the cycle right after the accepting edge, with rsp_rdata equal to zero.
- R9: The driver enable is never 1 while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Address to the RAM |
| mem_dq_out | output | 16 | Data toward the shared bus |
| mem_dq_in | input | 16 | Data returned from the shared bus |
| mem_dq_oe | output | 1 | Driver enable for the bus tristate buffer |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane strobes, active low, bit 0 lower byte |

## Verification
The bench's RAM model commits a write on the edge where the strobe overlap ends, and at that edge it checks that the address and data are still what they were during the overlap. A design that drops the data driver or moves the address together with the strobes therefore corrupts memory or reports a hold violation. The model returns garbage until the read strobes have been held for a full phase, so sampling one cycle early shows up as wrong read data. Partial-mask writes followed by full reads catch a strobe on the wrong lane. Writes that follow reads are timed to the cycle, which exposes a missing or misplaced turnaround cycle. Zero-mask requests must finish in one cycle with no chip select seen.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TURN   = 3'd1,
    ST_SETUP  = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_HOLD   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned PHASE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic last
);
  localparam int unsigned CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(PHASE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = RELOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == '0);

  // R2: a freshly loaded phase never ends early when it spans more than one cycle
  a_r2_phase_length: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (PHASE_CYC > 1)) |=> !last);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_lane_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic req_zero,
  input  logic phase_last,
  output logic req_ready,
  output logic accept,
  output logic load_timer,
  output logic sample_en,
  output logic strobe_on_d,
  output logic done,
  output logic cs_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe
);
  seq_state_e state_q, state_d;
  logic       wr_q, wr_d;
  logic       last_rd_q, last_rd_d;
  logic       done_q, done_d;
  logic       cs_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic       cs_n_d, we_n_d, oe_n_d, dq_oe_d;

  // next-state
  always_comb begin
    state_d    = state_q;
    wr_d       = wr_q;
    last_rd_d  = last_rd_q;
    done_d     = 1'b0;
    accept     = 1'b0;
    load_timer = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          wr_d   = req_write;
          if (req_zero) begin
            done_d = 1'b1;
          end else if (req_write && last_rd_q) begin
            state_d = ST_TURN;
          end else begin
            state_d    = ST_SETUP;
            load_timer = 1'b1;
          end
        end
      end
      ST_TURN: begin
        state_d    = ST_SETUP;
        load_timer = 1'b1;
      end
      ST_SETUP: begin
        if (phase_last) begin
          state_d    = ST_ACTIVE;
          load_timer = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (phase_last) begin
          state_d    = ST_HOLD;
          load_timer = 1'b1;
        end
      end
      ST_HOLD: begin
        if (phase_last) begin
          state_d   = ST_IDLE;
          done_d    = 1'b1;
          last_rd_d = !wr_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // pin decode from the next state so the pins flip with the state register
  always_comb begin
    strobe_on_d = (state_d == ST_ACTIVE);
    cs_n_d      = !strobe_on_d;
    we_n_d      = !(strobe_on_d && wr_d);
    oe_n_d      = !(strobe_on_d && !wr_d);
    dq_oe_d     = wr_d && ((state_d == ST_SETUP) || (state_d == ST_ACTIVE) ||
                           (state_d == ST_HOLD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_q      <= 1'b0;
      last_rd_q <= 1'b0;
      done_q    <= 1'b0;
      cs_n_q    <= 1'b1;
      we_n_q    <= 1'b1;
      oe_n_q    <= 1'b1;
      dq_oe_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      wr_q      <= wr_d;
      last_rd_q <= last_rd_d;
      done_q    <= done_d;
      cs_n_q    <= cs_n_d;
      we_n_q    <= we_n_d;
      oe_n_q    <= oe_n_d;
      dq_oe_q   <= dq_oe_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign sample_en = (state_q == ST_ACTIVE) && phase_last && !wr_q;
  assign done      = done_q;
  assign cs_n      = cs_n_q;
  assign we_n      = we_n_q;
  assign oe_n      = oe_n_q;
  assign dq_oe     = dq_oe_q;

  // R9: the controller and the RAM never drive the bus together
  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe_q && !oe_n_q));

  // R3: write strobe only inside chip select, output enable kept off
  a_r3_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> (oe_n_q && !cs_n_q && dq_oe_q));

  // R7: the turnaround cycle leaves the bus undriven on both sides
  a_r7_turn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TURN) |-> (oe_n_q && !dq_oe_q && cs_n_q));

  // R2: a completion pulse always lands while the sequencer is idle
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> req_ready);
endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         capture,
  input  logic                         strobe_on_d,
  input  logic                         sample_en,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  input  logic [DATA_W/LANE_W-1:0]     req_mask,
  input  logic [DATA_W-1:0]            mem_dq_in,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [DATA_W-1:0]            mem_dq_out,
  output logic [DATA_W/LANE_W-1:0]     mem_be_n,
  output logic [DATA_W-1:0]            rsp_rdata
);
  localparam int unsigned LANES = DATA_W / LANE_W;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [LANES-1:0]  mask_q, mask_d;
  logic [LANES-1:0]  be_n_q, be_n_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    mask_d  = mask_q;
    if (capture) begin
      addr_d  = req_addr;
      wdata_d = req_wdata;
      mask_d  = req_mask;
    end
    be_n_d = strobe_on_d ? ~mask_d : '1;
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    always_comb begin
      rdata_d[ln*LANE_W +: LANE_W] = rdata_q[ln*LANE_W +: LANE_W];
      if (capture) begin
        rdata_d[ln*LANE_W +: LANE_W] = '0;
      end else if (sample_en) begin
        rdata_d[ln*LANE_W +: LANE_W] = mask_q[ln] ? mem_dq_in[ln*LANE_W +: LANE_W]
                                                   : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      be_n_q  <= '1;
      rdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      mask_q  <= mask_d;
      be_n_q  <= be_n_d;
      rdata_q <= rdata_d;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_be_n   = be_n_q;
  assign rsp_rdata  = rdata_q;

  // R6: a strobed lane always belongs to the captured mask
  a_r6_lane_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ((~be_n_q & ~mask_q) == '0));
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PHASE_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [DATA_W/8-1:0]      req_mask,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_dq_out,
  input  logic [DATA_W-1:0]        mem_dq_in,
  output logic                     mem_dq_oe,
  output logic                     mem_cs_n,
  output logic                     mem_we_n,
  output logic                     mem_oe_n,
  output logic [DATA_W/8-1:0]      mem_be_n
);
  localparam int unsigned LANES = DATA_W / LANE_W;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic accept, load_timer, phase_last, sample_en, strobe_on_d;
  logic req_zero;
  assign req_zero = (req_mask == '0);

  sram_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (load_timer),
    .last  (phase_last)
  );

  sram_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_zero    (req_zero),
    .phase_last  (phase_last),
    .req_ready   (req_ready),
    .accept      (accept),
    .load_timer  (load_timer),
    .sample_en   (sample_en),
    .strobe_on_d (strobe_on_d),
    .done        (rsp_valid),
    .cs_n        (mem_cs_n),
    .we_n        (mem_we_n),
    .oe_n        (mem_oe_n),
    .dq_oe       (mem_dq_oe)
  );

  sram_lane_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .capture     (accept),
    .strobe_on_d (strobe_on_d),
    .sample_en   (sample_en),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_mask    (req_mask[LANES-1:0]),
    .mem_dq_in   (mem_dq_in),
    .mem_addr    (mem_addr),
    .mem_dq_out  (mem_dq_out),
    .mem_be_n    (mem_be_n),
    .rsp_rdata   (rsp_rdata)
  );

  // R4: address frozen for the whole access
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!req_ready && !$past(req_ready)) |-> $stable(mem_addr));

  // R4: write data unchanged while the driver is on
  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  // R8: a zero-mask request finishes next cycle without chip select
  a_r8_zero_mask: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_ready && (req_mask == '0)) |=> (rsp_valid && mem_cs_n));

  // R6: chip select never comes without a lane strobe
  a_r6_lane_with_cs: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mem_cs_n |-> (mem_be_n != '1));
endmodule

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
  localparam int PH = 2;
  localparam int AW = 18;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [1:0]    req_mask;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out, mem_dq_in;
  logic          mem_dq_oe, mem_cs_n, mem_we_n, mem_oe_n;
  logic [1:0]    mem_be_n;

  sram_lane_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PHASE_CYC(PH)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // scoreboard
  typedef struct {
    logic [DW-1:0] rdata;
    int            lat;
    bit            zero;
    int            acc;
  } exp_t;
  exp_t          sb[$];
  logic [DW-1:0] shadow[int];
  logic [DW-1:0] ram[int];
  int            pcyc = 0;
  bit            cs_seen = 0;
  bit            last_rd = 0;

  always @(posedge clk) pcyc++;

  // driver: computes the expected result and pushes it
  task automatic do_op(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] m);
    exp_t          e;
    bit            zero;
    bit            turn;
    logic [DW-1:0] cur;
    logic [DW-1:0] rexp;
    zero = (m == 2'b00);
    turn = wr && !zero && last_rd;
    cur  = shadow.exists(int'(a)) ? shadow[int'(a)] : '0;
    rexp = '0;
    for (int ln = 0; ln < 2; ln++) begin
      if (m[ln]) begin
        if (wr) cur[ln*8 +: 8] = d[ln*8 +: 8];
        else    rexp[ln*8 +: 8] = cur[ln*8 +: 8];
      end
    end
    if (wr) shadow[int'(a)] = cur;
    e.rdata = rexp;
    e.zero  = zero;
    e.lat   = zero ? 0 : (3 * PH + (turn ? 1 : 0));
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_mask  = m;
    @(posedge clk);
    #1;
    e.acc   = pcyc;
    cs_seen = 0;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    if (!zero) begin
      check(req_ready == 1'b0, "R2", "ready during access", req_ready, 0);
      check(mem_cs_n == 1'b1, "R2", "cs_n in first cycle", mem_cs_n, 1);
      if (wr) check(mem_dq_oe == !turn, "R7", "driver enable after accept",
                    mem_dq_oe, !turn);
      last_rd = !wr;
    end
  endtask

  // monitor: pops and compares responses
  always @(negedge clk) begin
    if (rst_n && !mem_cs_n) cs_seen = 1;
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(0, "R2", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_rdata == e.rdata, "R5", "response data", rsp_rdata, e.rdata);
        check((pcyc - e.acc) == e.lat, e.zero ? "R8" : "R2", "response latency",
              pcyc - e.acc, e.lat);
        check(cs_seen == !e.zero, "R8", "chip select seen", cs_seen, !e.zero);
      end
    end
  end

  // RAM model: commits on the end of the write overlap, data valid after a phase
  bit            p_wr = 0;
  bit            p_dq_oe = 0;
  bit            setup_ok = 0;
  bit            oe_bad = 0;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_dq;
  logic [1:0]    p_be;
  int            rd_cnt = 0;

  always @(negedge clk) begin
    bit            wr_act;
    bit            rd_act;
    logic [DW-1:0] word;
    wr_act = rst_n && !mem_cs_n && !mem_we_n && (mem_be_n != 2'b11);
    rd_act = rst_n && !mem_cs_n && mem_we_n && !mem_oe_n;
    if (wr_act && !p_wr) begin
      setup_ok = p_dq_oe;
      oe_bad   = 0;
    end
    if (wr_act && !mem_oe_n) oe_bad = 1;
    if (p_wr && !wr_act) begin
      check(mem_dq_oe && (mem_dq_out == p_dq) && (mem_addr == p_addr) && setup_ok,
            "R4", "data/address held past strobes", {mem_dq_oe, mem_dq_out}, {1'b1, p_dq});
      check(!oe_bad, "R3", "output enable high in write", oe_bad, 0);
      word = ram.exists(int'(p_addr)) ? ram[int'(p_addr)] : '0;
      for (int ln = 0; ln < 2; ln++)
        if (!p_be[ln]) word[ln*8 +: 8] = p_dq[ln*8 +: 8];
      ram[int'(p_addr)] = word;
    end
    if (wr_act) begin
      p_addr = mem_addr;
      p_dq   = mem_dq_out;
      p_be   = mem_be_n;
    end
    p_wr    = wr_act;
    p_dq_oe = mem_dq_oe;
    if (rd_act) rd_cnt++;
    else        rd_cnt = 0;
    if (rd_act && rd_cnt >= PH) begin
      word = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : '0;
      for (int ln = 0; ln < 2; ln++)
        if (mem_be_n[ln]) word[ln*8 +: 8] = 8'hA5;
      mem_dq_in = word;
    end else begin
      mem_dq_in = 16'hDEAD;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R2", "watchdog expired", 0, 1);
    wrap_up();
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    req_mask  = '0;
    repeat (4) @(negedge clk);
    check({mem_cs_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe, rsp_valid} == 7'b1111100,
          "R1", "pins during reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe, rsp_valid},
          7'b1111100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check({mem_cs_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe} == 6'b111110,
          "R1", "pins after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe},
          6'b111110);

    // R3 R4 full write, R5 read back
    do_op(1, 18'h00010, 16'h1234, 2'b11);
    do_op(0, 18'h00010, 16'h0000, 2'b11);
    do_op(0, 18'h00010, 16'h0000, 2'b11);
    // R7 write right after a read
    do_op(1, 18'h00011, 16'hBEEF, 2'b11);
    // R6 lane masks
    do_op(1, 18'h00010, 16'hAAFF, 2'b01);
    do_op(1, 18'h00010, 16'h56CC, 2'b10);
    do_op(0, 18'h00010, 16'h0000, 2'b11);
    do_op(0, 18'h00010, 16'h0000, 2'b01);
    do_op(0, 18'h00010, 16'h0000, 2'b10);
    // R8 zero mask: no effect on memory, read returns zero
    do_op(1, 18'h00010, 16'h0000, 2'b00);
    do_op(0, 18'h00010, 16'h0000, 2'b00);
    do_op(0, 18'h00010, 16'h0000, 2'b11);
    // R7 zero-mask read between write and write does not add a turn cycle
    do_op(1, 18'h00012, 16'h0F0F, 2'b11);
    do_op(0, 18'h00012, 16'h0000, 2'b00);
    do_op(1, 18'h00013, 16'hF0F0, 2'b11);
    // address extremes
    do_op(1, 18'h3FFFF, 16'hC3C3, 2'b11);
    do_op(1, 18'h00000, 16'h3C3C, 2'b11);
    do_op(0, 18'h3FFFF, 16'h0000, 2'b11);
    do_op(0, 18'h00000, 16'h0000, 2'b11);
    // mixed traffic
    for (int k = 0; k < 60; k++) begin
      logic [AW-1:0] a;
      a = {15'h1234, 3'($urandom_range(0, 7))};
      do_op(1'($urandom_range(0, 1)), a, 16'($urandom), 2'($urandom_range(0, 3)));
    end
    for (int k = 0; k < 8; k++) do_op(0, {15'h1234, 3'(k)}, 16'h0000, 2'b11);

    while (sb.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    wrap_up();
  end
endmodule